// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is a single channel of a programmable interval timer. A 16-bit presettable down counter counts either in binary or in four-digit BCD. It is paced by a count-enable pulse (`cnt_tick`) that stands in for the counter clock inside one system clock domain, qualified or triggered by a `gate` input, and it drives a single `out` pin. Software sets the channel up with a control word, loads the count as one or two byte writes, and reads the count back one byte at a time.

Two counting modes are built. In the terminal-count interrupt mode, `out` is low while the counter runs and goes high at zero. In the retriggerable one-shot mode, a rising edge on `gate` starts or restarts a low pulse on `out` lasting the programmed count. A latch command freezes a snapshot of the count so it can be read as two bytes while counting goes on.

Top module: `pit_channel`

## Requirements
- R1: A write with `sel_ctrl`=1 is a control word: bit 0 selects BCD (1) or binary (0), bits [3:1] select the mode (000 terminal-count interrupt, 001 one-shot), bits [5:4] select the access format (01 low byte only, 10 high byte only, 11 low byte then high byte, 00 latch command). A non-latch word whose mode is not 000 or 001, or whose bits [7:6] are not 00, is ignored. A write with `sel_ctrl`=0 is a count byte.
- R2: A control word for the terminal-count mode drives `out` low on the next cycle; one for the one-shot mode drives it high.
- R3: In terminal-count mode, a completed count N is copied into the counter on the first `cnt_tick` after the write edge; every later tick with `gate` high decrements it, and `out` rises in the cycle the counter reaches zero, N+1 ticks after the write.
- R4: In terminal-count mode `out` stays high after reaching zero until a new count is completed (which drives it low) or a control word is written.
- R5: In terminal-count mode `gate` low holds the count; the initial copy of the count still happens.
- R6: In terminal-count mode with format 11, the first byte freezes the counter until the second byte arrives; the completed count is then loaded on the next tick.
- R7: In one-shot mode `out` stays high after a count is written until a trigger; a rising `gate` loads the count on the first tick at or after the edge, drives `out` low, and `out` rises when the counter reaches zero. A steady high `gate` is not a trigger.
- R8: A trigger during a one-shot pulse reloads the count and `out` stays low.
- R9: A count written during a one-shot pulse does not change that pulse; it is used at the next trigger.
- R10: In BCD each 4-bit digit counts 9..0 with a borrow from the next digit; a loaded zero means 10000 ticks in BCD and 65536 in binary.
- R11: With `sel_ctrl`=0 and `rd_en`, `rd_data` gives the low byte (format 01), the high byte (format 10), or alternately low then high starting with low after a control word (format 11); reading never changes counting.
- R12: A latch command snapshots the count present in that cycle (before any decrement at the same edge); reads return the snapshot until the bytes of the format are read, and further latch commands are ignored meanwhile.
- R13: After reset `out` is low, the mode is terminal-count, binary, format 01, the count is 0 and nothing counts until a count is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe, consumes one byte |
| sel_ctrl | input | 1 | 1 = control word, 0 = count byte |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for the current read position |
| cnt_tick | input | 1 | Counter clock pulse, one system cycle wide |
| gate | input | 1 | Level enable (terminal-count) or trigger (one-shot) |
| out | output | 1 | Channel output |

## Verification
The latch command and a decrement can land on the same edge; the bench issues the latch while ticks run every cycle with a known count, and expects the snapshot to hold the value from before that edge, while `out` still rises at the tick computed from the original load. A second latch issued before the first snapshot is read is also placed mid-count and must not replace it. In one-shot mode a count write is placed inside a running pulse, and the end of that pulse is timed against the old count.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int DIGITS = CNT_W / 4;

    // control word field positions
    localparam int CW_BCD   = 0;
    localparam int CW_MODE  = 1;
    localparam int CW_MODEW = 3;
    localparam int CW_FMT   = 4;
    localparam int CW_RSV   = 6;

    typedef enum logic [1:0] {
        FMT_LATCH = 2'b00,
        FMT_LO    = 2'b01,
        FMT_HI    = 2'b10,
        FMT_BOTH  = 2'b11
    } acc_fmt_e;

    typedef struct packed {
        acc_fmt_e fmt;
        logic     oneshot;
        logic     bcd;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{fmt: FMT_LO, oneshot: 1'b0, bcd: 1'b0};

    function automatic logic [CNT_W-1:0] dec_count(input logic [CNT_W-1:0] v,
                                                   input logic bcd);
        logic [CNT_W-1:0] r;
        logic borrow;
        r = '0;
        if (!bcd) begin
            r = v - 1'b1;
        end else begin
            borrow = 1'b1;
            for (int d = 0; d < DIGITS; d++) begin
                if (borrow && v[d*4 +: 4] == 4'd0) begin
                    r[d*4 +: 4] = 4'd9;
                end else if (borrow) begin
                    r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
                    borrow = 1'b0;
                end else begin
                    r[d*4 +: 4] = v[d*4 +: 4];
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pit_wrctl.sv
module pit_wrctl
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              sel_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              cw_stb,
    output logic              cw_oneshot,
    output logic              latch_stb,
    output logic [CNT_W-1:0]  cr,
    output logic              cr_first,
    output logic              cr_done
);

    logic              hi_next_q;
    logic [BYTE_W-1:0] lo_stage_q;
    acc_fmt_e          fmt_f;
    logic [CW_MODEW-1:0] mode_f;
    logic              cw_wr, cnt_wr, mode_ok;

    assign fmt_f   = acc_fmt_e'(wr_data[CW_FMT +: 2]);
    assign mode_f  = wr_data[CW_MODE +: CW_MODEW];
    assign cw_wr   = wr_en && sel_ctrl;
    assign cnt_wr  = wr_en && !sel_ctrl;
    assign mode_ok = (mode_f == CW_MODEW'(0) || mode_f == CW_MODEW'(1))
                     && wr_data[BYTE_W-1:CW_RSV] == '0;

    assign latch_stb  = cw_wr && fmt_f == FMT_LATCH;
    assign cw_stb     = cw_wr && fmt_f != FMT_LATCH && mode_ok;
    assign cw_oneshot = mode_f[0];
    assign cr_first   = cnt_wr && cfg.fmt == FMT_BOTH && !hi_next_q;
    assign cr_done    = cnt_wr && (cfg.fmt != FMT_BOTH || hi_next_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= CFG_RESET;
            cr         <= '0;
            hi_next_q  <= 1'b0;
            lo_stage_q <= '0;
        end else if (cw_stb) begin
            cfg.fmt     <= fmt_f;
            cfg.oneshot <= cw_oneshot;
            cfg.bcd     <= wr_data[CW_BCD];
            hi_next_q   <= 1'b0;
        end else if (cnt_wr) begin
            case (cfg.fmt)
                FMT_LO:  cr <= CNT_W'(wr_data);
                FMT_HI:  cr <= {wr_data, {BYTE_W{1'b0}}};
                default: begin
                    if (hi_next_q) cr <= {wr_data, lo_stage_q};
                    else           lo_stage_q <= wr_data;
                    hi_next_q <= !hi_next_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             oneshot,
    input  logic             bcd,
    input  logic             cw_stb,
    input  logic             cw_oneshot,
    input  logic [CNT_W-1:0] cr,
    input  logic             cr_first,
    input  logic             cr_done,
    input  logic             cnt_tick,
    input  logic             gate,
    output logic [CNT_W-1:0] ce,
    output logic             out
);

    logic run_q, ld_pend_q, armed_q, trig_pend_q, hold_q, gate_q;
    logic trig, m0_load, m1_load, load_now, dec_en;
    logic [CNT_W-1:0] ce_dec;

    assign trig     = gate && !gate_q;
    assign m0_load  = !oneshot && ld_pend_q && cnt_tick;
    assign m1_load  = oneshot && armed_q && (trig || trig_pend_q) && cnt_tick;
    assign load_now = m0_load || m1_load;
    assign dec_en   = cnt_tick && run_q && !load_now
                      && (oneshot || (gate && !hold_q));
    assign ce_dec   = dec_count(ce, bcd);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce          <= '0;
            out         <= 1'b0;
            run_q       <= 1'b0;
            ld_pend_q   <= 1'b0;
            armed_q     <= 1'b0;
            trig_pend_q <= 1'b0;
            hold_q      <= 1'b0;
            gate_q      <= 1'b0;
        end else begin
            gate_q <= gate;
            if (cw_stb) begin
                out         <= cw_oneshot;
                run_q       <= 1'b0;
                ld_pend_q   <= 1'b0;
                armed_q     <= 1'b0;
                trig_pend_q <= 1'b0;
                hold_q      <= 1'b0;
            end else begin
                if (load_now) begin
                    ce          <= cr;
                    run_q       <= 1'b1;
                    ld_pend_q   <= 1'b0;
                    trig_pend_q <= 1'b0;
                    if (oneshot) out <= 1'b0;
                end else if (dec_en) begin
                    ce <= ce_dec;
                    if (ce_dec == '0) out <= 1'b1;
                end
                if (oneshot && armed_q && trig && !cnt_tick)
                    trig_pend_q <= 1'b1;
                if (cr_first && !oneshot)
                    hold_q <= 1'b1;
                if (cr_done) begin
                    if (oneshot) begin
                        armed_q <= 1'b1;
                    end else begin
                        ld_pend_q <= 1'b1;
                        hold_q    <= 1'b0;
                        out       <= 1'b0;
                    end
                end
            end
        end
    end

    // R3: in terminal-count mode out only rises with the counter at zero
    p_tc_out_r3: assert property (@(posedge clk) disable iff (rst)
        (!oneshot && $rose(out)) |-> ce == '0);

    // R4: out stays high until a new count or control word
    p_out_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (!oneshot && out && !cr_done && !cw_stb) |=> out);

    // R5: gate low freezes the running count
    p_gate_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!oneshot && run_q && !gate && !ld_pend_q) |=> $stable(ce));

    // R7: a one-shot pulse starts with the programmed count
    p_oneshot_load_r7: assert property (@(posedge clk) disable iff (rst)
        (oneshot && $fell(out)) |-> ce == $past(cr));

endmodule

// File: rtl/pit_rdctl.sv
module pit_rdctl
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              sel_ctrl,
    input  acc_fmt_e          fmt,
    input  logic              cw_stb,
    input  logic              latch_stb,
    input  logic [CNT_W-1:0]  ce,
    output logic [BYTE_W-1:0] rd_data
);

    logic             latched_q, rd_hi_q;
    logic [CNT_W-1:0] snap_q, src;
    logic             use_hi, rd, last;

    assign src     = latched_q ? snap_q : ce;
    assign use_hi  = fmt == FMT_HI || (fmt == FMT_BOTH && rd_hi_q);
    assign rd_data = use_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
    assign rd      = rd_en && !sel_ctrl;
    assign last    = fmt != FMT_BOTH || rd_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latched_q <= 1'b0;
            rd_hi_q   <= 1'b0;
            snap_q    <= '0;
        end else if (cw_stb) begin
            latched_q <= 1'b0;
            rd_hi_q   <= 1'b0;
        end else begin
            if (rd) begin
                if (fmt == FMT_BOTH) rd_hi_q <= !rd_hi_q;
                if (last) latched_q <= 1'b0;
            end
            if (latch_stb && !latched_q) begin
                latched_q <= 1'b1;
                snap_q    <= ce;
            end
        end
    end

    // R12: a held snapshot does not move
    p_snap_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (latched_q && $past(latched_q)) |-> $stable(snap_q));

    // R12: reading the final byte of the format releases the snapshot
    p_latch_release_r12: assert property (@(posedge clk) disable iff (rst)
        (rd && last && latched_q) |=> !latched_q);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       sel_ctrl,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       cnt_tick,
    input  logic       gate,
    output logic       out
);

    cfg_t             cfg;
    logic             cw_stb, cw_oneshot, latch_stb, cr_first, cr_done;
    logic [CNT_W-1:0] cr, ce;

    pit_wrctl u_wr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel_ctrl(sel_ctrl),
        .wr_data(wr_data), .cfg(cfg), .cw_stb(cw_stb),
        .cw_oneshot(cw_oneshot), .latch_stb(latch_stb), .cr(cr),
        .cr_first(cr_first), .cr_done(cr_done)
    );

    pit_core u_core (
        .clk(clk), .rst(rst), .oneshot(cfg.oneshot), .bcd(cfg.bcd),
        .cw_stb(cw_stb), .cw_oneshot(cw_oneshot), .cr(cr),
        .cr_first(cr_first), .cr_done(cr_done), .cnt_tick(cnt_tick),
        .gate(gate), .ce(ce), .out(out)
    );

    pit_rdctl u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .sel_ctrl(sel_ctrl),
        .fmt(cfg.fmt), .cw_stb(cw_stb), .latch_stb(latch_stb), .ce(ce),
        .rd_data(rd_data)
    );

endmodule

// File: tb/tb_pit_channel.sv
module tb_pit_channel;

    logic       clk = 1'b0;
    logic       rst, wr_en, rd_en, sel_ctrl, cnt_tick, gate;
    logic [7:0] wr_data, rd_data;
    logic       out;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pit_channel dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .sel_ctrl(sel_ctrl), .wr_data(wr_data), .rd_data(rd_data),
        .cnt_tick(cnt_tick), .gate(gate), .out(out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    // control word: [7:6]=00, [5:4] format, [3:1] mode, [0] bcd
    function automatic logic [7:0] cw(input logic [1:0] fmt, input logic [2:0] mode, input logic bcd);
        return {2'b00, fmt, mode, bcd};
    endfunction

    task automatic wr(input logic ctl, input logic [7:0] d);
        wr_en = 1'b1; sel_ctrl = ctl; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        sel_ctrl = 1'b0; rd_en = 1'b1;
        #1 b = rd_data;
        step(1);
        rd_en = 1'b0;
    endtask

    task automatic rd_word(output logic [15:0] w);
        logic [7:0] lo, hi;
        rd_byte(lo);
        rd_byte(hi);
        w = {hi, lo};
    endtask

    task automatic t_reset;
        logic [7:0] b;
        chk("R13 out after reset", out, 0);
        gate = 1'b1;
        step(5);
        rd_byte(b);
        chk("R13 count idle after reset", b, 8'h00);
        chk("R13 out idle", out, 0);
    endtask

    task automatic t_mode0;
        gate = 1'b1;
        wr(1, cw(2'b11, 3'd0, 0));
        chk("R2 mode0 cw out low", out, 0);
        wr(0, 8'h05); wr(0, 8'h00);
        step(5);
        chk("R3 out low before terminal", out, 0);
        step(1);
        chk("R3 out high at terminal", out, 1);
        step(20);
        chk("R4 out stays high", out, 1);
        wr(0, 8'h03);
        wr(0, 8'h00);
        chk("R4 new count drives out low", out, 0);
        step(3);
        chk("R3 second count not yet done", out, 0);
        step(1);
        chk("R3 second count terminal", out, 1);
        wr(1, cw(2'b01, 3'd1, 0));
        chk("R2 mode1 cw out high", out, 1);
        wr(1, cw(2'b01, 3'd2, 0));
        chk("R1 unsupported mode ignored", out, 1);
        wr(1, cw(2'b01, 3'd0, 0));
        chk("R2 mode0 cw again out low", out, 0);
    endtask

    task automatic t_gate_hold;
        logic [15:0] w;
        wr(1, cw(2'b11, 3'd0, 1));
        gate = 1'b0;
        wr(0, 8'h00); wr(0, 8'h01);
        step(3);
        rd_word(w);
        chk("R5 gate low holds loaded count", w, 16'h0100);
        gate = 1'b1; step(1); gate = 1'b0;
        rd_word(w);
        chk("R10 bcd borrow 0100->0099", w, 16'h0099);
        gate = 1'b1;
        step(98);
        chk("R5 out low before bcd zero", out, 0);
        step(1);
        chk("R10 out high at bcd zero", out, 1);
    endtask

    task automatic t_hi_byte;
        logic [7:0] b;
        wr(1, cw(2'b10, 3'd0, 0));
        gate = 1'b0;
        wr(0, 8'h12);
        step(2);
        rd_byte(b);
        chk("R11 high-byte format read", b, 8'h12);
    endtask

    task automatic t_first_byte;
        logic [15:0] a, b;
        wr(1, cw(2'b11, 3'd0, 0));
        gate = 1'b1;
        wr(0, 8'h32); wr(0, 8'h00);
        step(11);
        wr(0, 8'h02);
        rd_word(a);
        step(5);
        rd_word(b);
        chk("R6 first byte freezes count", b, a);
        chk("R6 frozen count nonzero", (a != 0), 1);
        wr(0, 8'h00);
        step(2);
        chk("R6 new count running", out, 0);
        step(1);
        chk("R6 new count of 2 ends", out, 1);
    endtask

    task automatic t_zero;
        wr(1, cw(2'b01, 3'd0, 1));
        gate = 1'b1;
        wr(0, 8'h10);
        step(10);
        chk("R10 bcd 10 not done", out, 0);
        step(1);
        chk("R10 bcd 10 done", out, 1);
        wr(0, 8'h00);
        step(10000);
        chk("R10 bcd zero before 10000", out, 0);
        step(1);
        chk("R10 bcd zero = 10000", out, 1);
        wr(1, cw(2'b01, 3'd0, 0));
        wr(0, 8'h00);
        step(65536);
        chk("R10 binary zero before 65536", out, 0);
        step(1);
        chk("R10 binary zero = 65536", out, 1);
    endtask

    task automatic t_mode1;
        gate = 1'b0;
        wr(1, cw(2'b01, 3'd1, 0));
        wr(0, 8'h05);
        step(5);
        chk("R7 out high until trigger", out, 1);
        gate = 1'b1; step(1);
        chk("R7 trigger drives out low", out, 0);
        step(4);
        chk("R7 pulse still low", out, 0);
        step(1);
        chk("R7 pulse ends at zero", out, 1);
        step(10);
        chk("R7 steady gate no retrigger", out, 1);
        gate = 1'b0; step(1);
        gate = 1'b1; step(3);
        gate = 1'b0; step(1);
        gate = 1'b1; step(5);
        chk("R8 retrigger keeps out low", out, 0);
        step(1);
        chk("R8 retriggered pulse ends", out, 1);
        gate = 1'b0; step(1);
        gate = 1'b1; step(1);
        wr(0, 8'h0A);
        step(3);
        chk("R9 pulse running on old count", out, 0);
        step(1);
        chk("R9 old count ends pulse", out, 1);
        gate = 1'b0; step(1);
        gate = 1'b1; step(10);
        chk("R9 new count used next trigger", out, 0);
        step(1);
        chk("R9 new count ends pulse", out, 1);
        gate = 1'b0; step(1);
        cnt_tick = 1'b0; gate = 1'b1; step(3);
        chk("R7 trigger waits for tick", out, 1);
        cnt_tick = 1'b1; step(1);
        chk("R7 pending trigger loads on tick", out, 0);
        step(10);
    endtask

    task automatic t_latch;
        logic [15:0] w;
        wr(1, cw(2'b11, 3'd0, 0));
        gate = 1'b1;
        wr(0, 8'h64); wr(0, 8'h00);
        step(10);
        wr(1, cw(2'b00, 3'd0, 0));
        step(5);
        wr(1, cw(2'b00, 3'd0, 0));
        step(3);
        rd_word(w);
        chk("R12 latched value before same-edge decrement", w, 16'h005B);
        step(78);
        chk("R11 reads do not disturb: still low", out, 0);
        step(1);
        chk("R11 reads do not disturb: terminal on time", out, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; sel_ctrl = 1'b0;
        wr_data = 8'h00; cnt_tick = 1'b1; gate = 1'b0;
        step(4);
        rst = 1'b0;
        step(1);
        t_reset();
        t_mode0();
        t_gate_hold();
        t_hi_byte();
        t_first_byte();
        t_mode1();
        t_latch();
        t_zero();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule